// File: doc/BRIEF.md
# Daisy-Chain Host Command Sequencer

This block is the host end of a serial chain of up to thirty identical slave devices. It takes single write or read requests from local logic and turns each one into 32-bit frames on a four-wire serial link. Clock polarity is 0 and the sample phase is 1. Each frame carries a 12-bit CRC in its low bits, computed over the upper twenty bits.

A write becomes one write-only frame at the faster link rate. A read becomes a pointer command, broadcast to every device, followed by one all-zero frame per device in the chain, all at the slower bidirectional rate. The word shifted in during each zero frame is handed back on a valid-only response stream, closest device first, with a flag on the final word.

The sequencer enforces a quiet gap before write-only traffic that follows bidirectional traffic. Link rates and the gap length are derived from a system-clock frequency parameter.

Top module: `dch_host_seq`

## Requirements
- R1: Each frame is 32 bits, sent MSB first. Bits 31:27 hold the device address. Bit 26 is the direction flag: 1 for write-only, 0 for bidirectional. Bits 25:20 hold the register address, bits 19:12 the data byte, and bits 11:0 the CRC.
- R2: The CRC covers frame bits 31:12 MSB first. It uses polynomial x^12+x^10+x^9+x^7+x+1 (low terms 0x683), a zero start value and no final inversion, so an all-zero header gives CRC 0.
- R3: The link idles with sclk low and cs_n high. cs_n low frames exactly 32 sclk high pulses. mosi changes only when sclk rises and is stable while sclk is high. miso is captured when sclk falls.
- R4: A write request produces exactly one frame, with the requested device address, direction flag 1, the requested register and the requested data.
- R5: A read request produces a command frame first. It carries device address 0x1F, direction flag 0, register 0x3F, and data {2'b00, requested register}. N frames follow, each all 32 bits zero, where N is the effective device count.
- R6: Each zero frame yields one response word equal to the 32 bits captured on miso during it, in chain order. The command frame yields no response. rsp_last is high only with the N-th word.
- R7: dev_count is sampled when a request is accepted. A value of 0 is treated as 1 and a value above 30 as 30.
- R8: The sclk high and low times are each ceil(CLK_HZ/1_450_000) cycles in write frames and ceil(CLK_HZ/1_000_000) cycles in read frames.
- R9: A write accepted after a read keeps cs_n high for at least ceil(CLK_HZ/20_000) cycles (50 µs) between the end of the read's last frame and the start of the write frame. A write after a write, or a read after a read, has no such delay.
- R10: req_ready is high in idle and after reset. It is low from acceptance until the whole sequence, including any turnaround delay, has finished. Reset, also in mid-sequence, returns cs_n high, sclk low, mosi low and rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Device address for writes |
| req_reg | input | 6 | Register address |
| req_data | input | 8 | Data byte for writes |
| dev_count | input | 5 | Number of devices in the chain |
| rsp_valid | output | 1 | Response word present (one cycle) |
| rsp_data | output | 32 | Word returned by one device |
| rsp_last | output | 1 | Marks the word from the last device |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Frame select, active low |
| mosi | output | 1 | Serial data to the chain |
| miso | input | 1 | Serial data from the chain |

## Verification
On every cycle, the assertions guard the link's framing rules. These are: sclk only inside a frame, 32 rising edges per frame, and mosi held while sclk is high. They also check that the link stays silent during the turnaround wait, that zero frames stay zero, that ready never coincides with a live frame, and that the last flag only comes with a valid word.

Only the bench scenarios can show the rest: the exact frame contents and CRC, the per-mode sclk widths, and the length of the turnaround gap against the preceding traffic. They also cover response ordering, the clamping of out-of-range device counts, and recovery from a reset in mid-read.

// File: rtl/dch_pkg.sv
package dch_pkg;
  localparam logic [4:0] ALL_DEV  = 5'h1F;
  localparam logic [5:0] PTR_REG  = 6'h3F;
  localparam int         MAX_DEV  = 30;
  localparam logic [11:0] CRC_POLY = 12'h683;

  typedef struct packed {
    logic [4:0] dev;
    logic       one_way;
    logic [5:0] rega;
    logic [7:0] data;
  } hdr_t;

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_GO, S_RUN} seq_st_t;
endpackage

// File: rtl/dch_crc12.sv
module dch_crc12 #(
  parameter int          DW   = 20,
  parameter logic [11:0] POLY = 12'h683
) (
  input  logic [DW-1:0] din,
  output logic [11:0]   crc
);
  logic [DW:0][11:0] st;

  assign st[0] = '0;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic fb;
    assign fb = din[DW-1-i] ^ st[i][11];
    assign st[i+1] = {st[i][10:0], 1'b0} ^ (fb ? POLY : 12'h000);
  end

  assign crc = st[DW];

  always_comb begin
    if (din == '0) begin
      assert_zero_in_R2: assert (crc == 12'h000);
    end
  end
endmodule

// File: rtl/dch_turn_timer.sv
module dch_turn_timer #(
  parameter int CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy,
  output logic expire
);
  localparam int W = $clog2(CYC + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      expire <= 1'b0;
      cnt    <= '0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= W'(CYC - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_load_idle_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
endmodule

// File: rtl/dch_spi_frame.sv
module dch_spi_frame #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     tx_word,
  input  logic [DIVW-1:0] half,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [31:0]     rx_word,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi
);
  typedef enum logic [2:0] {P_IDLE, P_LEAD, P_HI, P_LO, P_TAIL} ph_t;

  ph_t            ph;
  logic [DIVW-1:0] tmr, half_q;
  logic [31:0]    sh, rx;
  logic [4:0]     bitn;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= P_IDLE;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      mosi   <= 1'b0;
      done   <= 1'b0;
      tmr    <= '0;
      half_q <= '0;
      sh     <= '0;
      rx     <= '0;
      bitn   <= '0;
    end else begin
      done <= 1'b0;
      if (ph == P_IDLE) begin
        if (start) begin
          cs_n   <= 1'b0;
          sh     <= tx_word;
          half_q <= half;
          tmr    <= half - 1'b1;
          bitn   <= '0;
          ph     <= P_LEAD;
        end
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        tmr <= half_q - 1'b1;
        if (ph == P_LEAD) begin
          sclk <= 1'b1;
          mosi <= sh[31];
          sh   <= {sh[30:0], 1'b0};
          ph   <= P_HI;
        end else if (ph == P_HI) begin
          sclk <= 1'b0;
          rx   <= {rx[30:0], miso};
          ph   <= P_LO;
        end else if (ph == P_LO) begin
          if (bitn == 5'd31) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            ph   <= P_TAIL;
          end else begin
            sclk <= 1'b1;
            mosi <= sh[31];
            sh   <= {sh[30:0], 1'b0};
            bitn <= bitn + 1'b1;
            ph   <= P_HI;
          end
        end else begin
          done <= 1'b1;
          ph   <= P_IDLE;
        end
      end
    end
  end

  assign busy    = (ph != P_IDLE);
  assign rx_word = rx;

  // checker state: rising sclk edges seen inside the current frame
  logic       sclk_d;
  logic [5:0] rises;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n && !sclk) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  assert_sclk_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_pulse_count_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rises == 6'd32));
endmodule

// File: rtl/dch_host_seq.sv
module dch_host_seq
  import dch_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_dev,
  input  logic [5:0]  req_reg,
  input  logic [7:0]  req_data,
  input  logic [4:0]  dev_count,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_last,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int HALF_UNI = (CLK_HZ + 1_449_999) / 1_450_000;
  localparam int HALF_BI  = (CLK_HZ + 999_999) / 1_000_000;
  localparam int TURN_CYC = (CLK_HZ + 19_999) / 20_000;
  localparam int DIVW     = $clog2(HALF_BI + 1);

  seq_st_t     st;
  hdr_t        hdr_q;
  logic        is_read, null_sel, last_bidir;
  logic [4:0]  ndev, idx, cnt_c;
  logic [11:0] crc;
  logic [31:0] tx_word, rx_word;
  logic [DIVW-1:0] half_sel;
  logic        f_busy, f_done, t_busy, t_expire, accept, t_load;

  dch_crc12 #(.DW(20), .POLY(CRC_POLY)) u_crc (
    .din (hdr_q),
    .crc (crc)
  );

  assign tx_word  = null_sel ? 32'h0 : {hdr_q, crc};
  assign half_sel = is_read ? DIVW'(HALF_BI) : DIVW'(HALF_UNI);

  dch_spi_frame #(.DIVW(DIVW)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .start   (st == S_GO),
    .tx_word (tx_word),
    .half    (half_sel),
    .miso    (miso),
    .busy    (f_busy),
    .done    (f_done),
    .rx_word (rx_word),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi)
  );

  assign req_ready = (st == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign t_load    = accept && req_write && last_bidir;

  dch_turn_timer #(.CYC(TURN_CYC)) u_turn (
    .clk    (clk),
    .rst    (rst),
    .load   (t_load),
    .busy   (t_busy),
    .expire (t_expire)
  );

  always_comb begin
    if (dev_count == 5'd0)                 cnt_c = 5'd1;
    else if (dev_count > 5'(MAX_DEV))      cnt_c = 5'(MAX_DEV);
    else                                   cnt_c = dev_count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      hdr_q      <= '0;
      is_read    <= 1'b0;
      null_sel   <= 1'b0;
      last_bidir <= 1'b0;
      ndev       <= 5'd1;
      idx        <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_last   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_write)
              hdr_q <= '{dev: req_dev, one_way: 1'b1, rega: req_reg, data: req_data};
            else
              hdr_q <= '{dev: ALL_DEV, one_way: 1'b0, rega: PTR_REG, data: {2'b00, req_reg}};
            is_read  <= !req_write;
            null_sel <= 1'b0;
            ndev     <= cnt_c;
            idx      <= '0;
            st       <= (req_write && last_bidir) ? S_TURN : S_GO;
          end
        end
        S_TURN: begin
          if (t_expire) begin
            last_bidir <= 1'b0;
            st         <= S_GO;
          end
        end
        S_GO: st <= S_RUN;
        default: begin
          if (f_done) begin
            if (null_sel) begin
              rsp_valid <= 1'b1;
              rsp_data  <= rx_word;
              rsp_last  <= (idx == ndev);
            end
            if (is_read && idx != ndev) begin
              idx      <= idx + 1'b1;
              null_sel <= 1'b1;
              st       <= S_GO;
            end else begin
              last_bidir <= is_read;
              st         <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  assert_quiet_turn_R9: assert property (@(posedge clk) disable iff (rst)
    (st == S_TURN) |-> (cs_n && (t_busy || t_expire)));
  assert_null_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (null_sel && sclk) |-> !mosi);
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_last |-> rsp_valid);
  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (cs_n && !f_busy));
endmodule

// File: tb/sim_dch_host_seq.sv
module sim_dch_host_seq;
  // CLK_HZ = 10 MHz: write half = 7, read half = 10, turnaround = 500 cycles
  localparam int CLK_HZ = 10_000_000;
  localparam int HU = 7;
  localparam int HB = 10;
  localparam int TURN = 500;
  localparam int NV = 8;
  // entry: {write, dev[4:0], reg[5:0], data[7:0], count[4:0]}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 5'd3,  6'h12, 8'hA7, 5'd4},
    {1'b1, 5'h1F, 6'h01, 8'h04, 5'd1},
    {1'b0, 5'd0,  6'h2A, 8'h00, 5'd3},
    {1'b0, 5'd0,  6'h01, 8'h00, 5'd0},
    {1'b1, 5'd0,  6'h3E, 8'hFF, 5'd2},
    {1'b0, 5'd7,  6'h15, 8'h00, 5'd31},
    {1'b0, 5'd9,  6'h00, 8'h00, 5'd30},
    {1'b1, 5'h1D, 6'h00, 8'h00, 5'd2}
  };

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, miso = 0;
  logic [4:0] req_dev = 0, dev_count = 1;
  logic [5:0] req_reg = 0;
  logic [7:0] req_data = 0;
  logic req_ready, rsp_valid, rsp_last, sclk, cs_n, mosi;
  logic [31:0] rsp_data;

  always #2 clk = ~clk;

  dch_host_seq #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_reg(req_reg),
    .req_data(req_data), .dev_count(dev_count), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  int total = 0, bad = 0;
  int cyc = 0, rise_cyc = 0, fall_gap = 0, bitcnt = 0, hrun = 0, hw = 0;
  int nfr = 0, nrsp = 0;
  logic [31:0] sh = 0;
  logic [31:0] frm [32];
  int fbits [32], fhw [32], fgap [32];
  logic [31:0] rsp [32];
  logic rlast [32];
  logic prev_cs = 1, prev_sclk = 0;

  function automatic logic [11:0] crc_ref(input logic [19:0] d);
    logic [11:0] c = 12'h0;
    for (int i = 19; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ c[11];
      c = {c[10:0], 1'b0};
      if (fb) c = c ^ 12'h683;
    end
    return c;
  endfunction

  function automatic logic [31:0] slv_word(input int f);
    return {8'h3C, 8'(f), 8'(f * 7), 8'hC3};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // link monitor and slave model, sampled away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_cs && !cs_n) begin
        fall_gap = cyc - rise_cyc;
        bitcnt = 0;
        sh = 0;
      end
      if (!prev_sclk && sclk) miso = slv_word(nfr)[31 - (bitcnt % 32)];
      if (sclk) hrun++;
      if (prev_sclk && !sclk) begin
        hw = hrun;
        hrun = 0;
        sh = {sh[30:0], mosi};
        bitcnt++;
      end
      if (!prev_cs && cs_n) begin
        if (nfr < 32) begin
          frm[nfr] = sh; fbits[nfr] = bitcnt; fhw[nfr] = hw; fgap[nfr] = fall_gap;
        end
        nfr++;
        rise_cyc = cyc;
      end
      if (rsp_valid && nrsp < 32) begin
        rsp[nrsp] = rsp_data;
        rlast[nrsp] = rsp_last;
        nrsp++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic do_req(input logic w, input logic [4:0] dv, input logic [5:0] rg,
                        input logic [7:0] dt, input logic [4:0] cnt);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    nfr = 0; nrsp = 0;
    req_valid = 1; req_write = w; req_dev = dv; req_reg = rg; req_data = dt; dev_count = cnt;
    @(posedge clk); #1;
    req_valid = 0;
    chk(req_ready == 1'b0, "R10 ready low after accept", {31'b0, req_ready}, 32'h0);
    while (!req_ready) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] exp_cmd(input logic w, input logic [4:0] dv,
                                          input logic [5:0] rg, input logic [7:0] dt);
    logic [19:0] h;
    h = w ? {dv, 1'b1, rg, dt} : {5'h1F, 1'b0, 6'h3F, 2'b00, rg};
    return {h, crc_ref(h)};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=busy exp=idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic prev_read;
    repeat (3) @(posedge clk);
    #1;
    // reset state (R10, R3)
    chk(cs_n == 1'b1, "R10 reset cs_n", {31'b0, cs_n}, 32'h1);
    chk(sclk == 1'b0, "R3 reset sclk", {31'b0, sclk}, 32'h0);
    chk(mosi == 1'b0, "R10 reset mosi", {31'b0, mosi}, 32'h0);
    chk(rsp_valid == 1'b0, "R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rst = 0;
    @(posedge clk); #1;
    chk(req_ready == 1'b1, "R10 ready after reset", {31'b0, req_ready}, 32'h1);
    // CRC of an all-zero header (R2)
    chk(crc_ref(20'h0) == 12'h0, "R2 zero crc", {20'h0, crc_ref(20'h0)}, 32'h0);

    prev_read = 0;
    for (int v = 0; v < NV; v++) begin
      logic w;
      logic [4:0] dv, cnt;
      logic [5:0] rg;
      logic [7:0] dt;
      int n, nexp;
      {w, dv, rg, dt, cnt} = VEC[v];
      n = (cnt == 0) ? 1 : (cnt > 30) ? 30 : int'(cnt);     // R7
      nexp = w ? 1 : n + 1;
      do_req(w, dv, rg, dt, cnt);
      chk(nfr == nexp, w ? "R4 frame count" : "R5 R7 frame count", nfr, nexp);
      chk(frm[0] == exp_cmd(w, dv, rg, dt), w ? "R1 R2 R4 write frame" : "R1 R2 R5 read cmd",
          frm[0], exp_cmd(w, dv, rg, dt));
      chk(fbits[0] == 32, "R3 bits per frame", fbits[0], 32);
      chk(fhw[0] == (w ? HU : HB), "R8 sclk half period", fhw[0], w ? HU : HB);
      if (v > 0) begin
        if (w && prev_read)
          chk(fgap[0] >= TURN, "R9 turnaround gap", fgap[0], TURN);
        else
          chk(fgap[0] < TURN, "R9 no needless delay", fgap[0], TURN);
      end
      if (!w) begin
        chk(nrsp == n, "R6 R7 response count", nrsp, n);
        for (int k = 1; k <= n && k < 32; k++) begin
          chk(frm[k] == 32'h0, "R5 null frame", frm[k], 32'h0);
          chk(fhw[k] == HB, "R8 read half period", fhw[k], HB);
          chk(rsp[k-1] == slv_word(k), "R6 response order", rsp[k-1], slv_word(k));
          chk(rlast[k-1] == (k == n), "R6 last flag", {31'b0, rlast[k-1]}, {31'b0, k == n});
        end
      end else begin
        chk(nrsp == 0, "R6 no response on write", nrsp, 0);
      end
      prev_read = !w;
    end

    // reset in the middle of a read (R10)
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_reg = 6'h05; dev_count = 5'd5;
    @(posedge clk); #1;
    req_valid = 0;
    repeat (2000) @(posedge clk);
    #1; rst = 1;
    repeat (2) @(posedge clk);
    #1;
    chk(cs_n == 1'b1, "R10 mid reset cs_n", {31'b0, cs_n}, 32'h1);
    chk(sclk == 1'b0, "R10 mid reset sclk", {31'b0, sclk}, 32'h0);
    chk(mosi == 1'b0, "R10 mid reset mosi", {31'b0, mosi}, 32'h0);
    chk(req_ready == 1'b1, "R10 mid reset ready", {31'b0, req_ready}, 32'h1);
    rst = 0;
    repeat (20) @(posedge clk);
    do_req(1'b1, 5'd6, 6'h21, 8'h5C, 5'd3);
    chk(nfr == 1, "R4 write after reset count", nfr, 1);
    chk(frm[0] == exp_cmd(1'b1, 5'd6, 6'h21, 8'h5C), "R4 write after reset",
        frm[0], exp_cmd(1'b1, 5'd6, 6'h21, 8'h5C));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule